// File: doc/BRIEF.md
# Burst Round-Robin Bus Arbiter

This block shares one bus among a set of masters, sixteen by default. Each master has one request line. The arbiter answers with a grant vector that holds at most one set bit. The grant is formed combinationally from the current requests and a small amount of registered tenure state. Because of this, a master that asks while the bus is idle or being released is served in the same cycle, and the bus never sits idle while any master is asking.

A master that wins the bus may keep it for a burst of at most `BURST_LEN` consecutive cycles, eight by default. If other masters are waiting when that burst ends, ownership passes to the next requester in rotating order. The owner may not start a second burst while others wait. The search for the next owner begins just past the last owner and wraps from the highest index to zero. The last owner therefore always ranks last, including after a period in which nobody requested.

A master that requests alone may keep the bus for as long as it likes. The outcome is a fixed bound on waiting time: a master that holds its request is granted within (masters − 1) × (burst + 1) + 1 cycles, which is 136 cycles with the default parameters.

Top module: `burst_rr_arbiter`

## Requirements
- R1: The grant vector never has more than one bit set.
- R2: A grant bit is set only while the request bit of the same index is set. With no request active, the grant vector is all zeros.
- R3: Whenever any request bit is set, some grant bit is set in that same cycle.
- R4: If other masters are requesting, an owner keeps the grant for at most `BURST_LEN` consecutive cycles of one tenure. After that cycle, the grant moves to a different requesting master.
- R5: A new owner is chosen by scanning request indices upward, starting at one past the previous owner and wrapping from index N−1 to index 0. The first requester found wins.
- R6: If the owner drops its request before its burst ends, a waiting master is granted in that same cycle, with no idle cycle in between.
- R7: A master that is the only requester keeps its grant without interruption for any number of cycles.
- R8: After cycles with no request at all, the previous owner is still ranked last. Any other requester that appears at the same time as the previous owner is granted before it.
- R9: A master that keeps its request asserted waits fewer than (N−1)·(BURST_LEN+1)+1 cycles before it is granted (136 with the defaults).
- R10: Reset is synchronous and active-high. It ends any tenure and sets the scan start to index 0, so the first grant after reset goes to the lowest-indexed requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | One request bit per master |
| gnt | output | N_MASTERS | Zero or one-hot grant, valid in the same cycle as `req` |

## Verification
The bench goes after the points where an arbiter that is almost right fails.

- A master that asks alone past the burst limit must not lose the bus. A design that forces a change would drop its grant for a cycle.
- An owner that releases early must be followed by a waiting master in the same cycle. A registered grant would insert an idle cycle at that point.
- A quiet bus must not hand the next grant back to the previous owner. A pointer that resets to the owner would do exactly that.
- The scan must wrap from the top index to zero, and the first grant after reset must go to the lowest requester.

Long stretches with every master requesting test the waiting bound and the burst limit. Randomly toggling request patterns compare every cycle's grant against a reference computed in the bench.

// File: rtl/bra_pkg.sv
`timescale 1ns/1ps
package bra_pkg;

    // Default sizing for the arbiter
    localparam int unsigned DEF_MASTERS = 16;
    localparam int unsigned DEF_BURST   = 8;

    // Per-cycle decision taken by the arbiter
    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,   // nobody requests: no grant
        SEL_HOLD = 2'd1,   // current owner continues its burst
        SEL_NEW  = 2'd2    // rotating scan chooses an owner
    } sel_e;

    // Worst-case number of cycles a persistent requester may wait
    function automatic int unsigned wait_bound(input int unsigned n,
                                               input int unsigned b);
        return (n - 1) * (b + 1) + 1;
    endfunction

    // Index that follows i in a ring of n entries
    function automatic int unsigned ring_next(input int unsigned i,
                                              input int unsigned n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

endpackage

// File: rtl/bra_rr_pick.sv
`timescale 1ns/1ps
// Rotating first-one search: scans upward from ptr, wraps at N-1.
module bra_rr_pick #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int unsigned k = 0; k < N; k++) begin
            int unsigned p;
            p = int'(ptr) + k;
            if (p >= N) p = p - N;
            if (!found && req[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/bra_tenure.sv
`timescale 1ns/1ps
// Registered tenure state: owner, burst cycle count, scan start pointer.
module bra_tenure
    import bra_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned B  = 8,
    parameter int unsigned IW = $clog2(N),
    parameter int unsigned CW = $clog2(B + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  sel_e          sel,
    input  logic [IW-1:0] new_idx,
    output logic [IW-1:0] owner,
    output logic          owner_vld,
    output logic [CW-1:0] used,
    output logic [IW-1:0] ptr
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner     <= '0;
            owner_vld <= 1'b0;
            used      <= '0;
            ptr       <= '0;
        end else begin
            unique case (sel)
                SEL_HOLD: begin
                    used <= used + CW'(1);
                end
                SEL_NEW: begin
                    owner     <= new_idx;
                    owner_vld <= 1'b1;
                    used      <= CW'(1);
                    ptr       <= (new_idx == LAST) ? '0 : new_idx + IW'(1);
                end
                default: begin
                    owner_vld <= 1'b0;
                    used      <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/burst_rr_arbiter.sv
`timescale 1ns/1ps
module burst_rr_arbiter
    import bra_pkg::*;
#(
    parameter int unsigned N_MASTERS = DEF_MASTERS,
    parameter int unsigned BURST_LEN = DEF_BURST
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    output logic [N_MASTERS-1:0] gnt
);
    localparam int unsigned IW = $clog2(N_MASTERS);
    localparam int unsigned CW = $clog2(BURST_LEN + 1);

    logic [IW-1:0] owner;
    logic          owner_vld;
    logic [CW-1:0] used;
    logic [IW-1:0] ptr;
    logic          pick_found;
    logic [IW-1:0] pick_idx;
    logic          keep;
    sel_e          sel;

    bra_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
        .req   (req),
        .ptr   (ptr),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Owner continues while it still asks and its burst has room
    assign keep = owner_vld && req[owner] && (used < CW'(BURST_LEN));

    always_comb begin
        if (keep)            sel = SEL_HOLD;
        else if (pick_found) sel = SEL_NEW;
        else                 sel = SEL_IDLE;
    end

    bra_tenure #(.N(N_MASTERS), .B(BURST_LEN), .IW(IW), .CW(CW)) u_ten (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .new_idx   (pick_idx),
        .owner     (owner),
        .owner_vld (owner_vld),
        .used      (used),
        .ptr       (ptr)
    );

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_gnt
        assign gnt[i] = ((sel == SEL_HOLD) && (owner == IW'(i))) ||
                        ((sel == SEL_NEW)  && (pick_idx == IW'(i)));
    end
endmodule

// File: rtl/bra_chk.sv
`timescale 1ns/1ps
module bra_chk
    import bra_pkg::*;
#(
    parameter int unsigned N = 16,
    parameter int unsigned B = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt
);
    localparam int unsigned BOUND = wait_bound(N, B);
    localparam int unsigned RW    = $clog2(B + 2) + 1;
    localparam int unsigned WW    = $clog2(BOUND + 2) + 1;

    logic          multi;
    logic [N-1:0]  prev_gnt;
    logic [RW-1:0] run_q;

    assign multi = ($countones(req) > 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_gnt <= '0;
            run_q    <= '0;
        end else begin
            prev_gnt <= gnt;
            if (multi && (gnt != '0) && (gnt == prev_gnt)) begin
                if (run_q != '1) run_q <= run_q + RW'(1);
            end else begin
                run_q <= '0;
            end
        end
    end

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R2
    grant_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    // R3
    no_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (gnt != '0));

    // R4
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(B));

    // R6
    release_handover_chk: assert property (@(posedge clk) disable iff (rst)
        ((prev_gnt & req) == '0 && req != '0) |-> (gnt != '0));

    for (genvar i = 0; i < N; i++) begin : g_wait
        logic [WW-1:0] wait_q;
        always_ff @(posedge clk) begin
            if (rst)                   wait_q <= '0;
            else if (req[i] && !gnt[i]) begin
                if (wait_q != '1) wait_q <= wait_q + WW'(1);
            end else                   wait_q <= '0;
        end
        // R9
        wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
            wait_q < WW'(BOUND));
    end
endmodule

bind burst_rr_arbiter bra_chk #(.N(N_MASTERS), .B(BURST_LEN)) u_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
);

// File: tb/burst_rr_arbiter_test.sv
`timescale 1ns/1ps
module burst_rr_arbiter_test;
    localparam int N = 16;
    localparam int B = 8;
    localparam int BOUND = (N - 1) * (B + 1) + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // bench reference state
    int m_owner = 0;
    bit m_vld = 0;
    int m_cnt = 0;
    int m_ptr = 0;
    int wt [N];
    int maxw = 0;

    burst_rr_arbiter #(.N_MASTERS(N), .BURST_LEN(B)) uut (
        .clk (clk), .rst (rst), .req (req), .gnt (gnt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string rq,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic bit ref_keep(input logic [N-1:0] r);
        return m_vld && r[m_owner] && (m_cnt < B);
    endfunction

    function automatic int ref_pick(input logic [N-1:0] r);
        for (int k = 0; k < N; k++) begin
            int p;
            p = (m_ptr + k) % N;
            if (r[p]) return p;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] ref_grant(input logic [N-1:0] r);
        int p;
        if (ref_keep(r)) return N'(1) << m_owner;
        p = ref_pick(r);
        if (p < 0) return '0;
        return N'(1) << p;
    endfunction

    task automatic ref_reset();
        m_owner = 0; m_vld = 0; m_cnt = 0; m_ptr = 0;
        for (int i = 0; i < N; i++) wt[i] = 0;
    endtask

    task automatic ref_step(input logic [N-1:0] r);
        int p;
        if (ref_keep(r)) begin
            m_cnt++;
        end else begin
            p = ref_pick(r);
            if (p < 0) begin
                m_vld = 0; m_cnt = 0;
            end else begin
                m_owner = p; m_vld = 1; m_cnt = 1; m_ptr = (p + 1) % N;
            end
        end
    endtask

    // one clock: drive at negedge, sample 1 ns later, advance reference
    task automatic cyc(input logic [N-1:0] r, input string tag);
        logic [N-1:0] e;
        @(negedge clk);
        req = r;
        #1;
        e = ref_grant(r);
        chk(gnt == e, tag, gnt, e);
        chk($onehot0(gnt), "R1", gnt, e);
        chk((gnt & ~r) == '0, "R2", gnt, r);
        chk((r == '0) || (gnt != '0), "R3", gnt, e);
        for (int i = 0; i < N; i++) begin
            if (r[i] && !gnt[i]) wt[i]++; else wt[i] = 0;
            if (wt[i] > maxw) maxw = wt[i];
        end
        ref_step(r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(gnt == '0, "R10 reset idle", gnt, '0);
        rst = 1'b0;
        ref_reset();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] r;
        int run;
        void'($urandom(32'h1a2b3c4d));

        // R10: first grant after reset is the lowest requester
        do_reset();
        cyc(16'h0208, "R10 first grant");
        chk(gnt == 16'h0008, "R10 lowest index", gnt, 16'h0008);

        // R7: sole requester keeps bus far beyond the burst length
        do_reset();
        for (int i = 0; i < 3 * B + 4; i++) begin
            cyc(16'h0020, "R7 sole owner");
            chk(gnt == 16'h0020, "R7 continuous", gnt, 16'h0020);
        end

        // R4: two contenders alternate every BURST_LEN cycles
        do_reset();
        run = 0;
        for (int i = 0; i < B; i++) begin
            cyc(16'h0084, "R4 burst");
            if (gnt == 16'h0004) run++;
        end
        chk(run == B, "R4 full burst length", N'(run), N'(B));
        cyc(16'h0084, "R4 handover");
        chk(gnt == 16'h0080, "R4 handover after burst", gnt, 16'h0080);

        // R6: owner 7 drops early, master 2 granted same cycle
        cyc(16'h0084, "R6 setup");
        cyc(16'h0004, "R6 release");
        chk(gnt == 16'h0004, "R6 same-cycle handover", gnt, 16'h0004);

        // R8: quiet bus, then previous owner (2) and master 1 return together
        cyc(16'h0000, "R8 quiet");
        chk(gnt == '0, "R2 quiet no grant", gnt, '0);
        cyc(16'h0000, "R8 quiet");
        cyc(16'h0006, "R8 return");
        chk(gnt == 16'h0002, "R8 previous owner ranked last", gnt, 16'h0002);

        // R5: wrap from top index to zero
        do_reset();
        cyc(16'h4000, "R5 owner 14");
        cyc(16'h0000, "R5 quiet");
        cyc(16'h4002, "R5 wrap");
        chk(gnt == 16'h0002, "R5 wrap to low index", gnt, 16'h0002);
        cyc(16'h0000, "R5 quiet");
        cyc(16'h8006, "R5 scan upward");
        chk(gnt == 16'h0004, "R5 next above owner", gnt, 16'h0004);

        // R9: all masters request continuously
        do_reset();
        maxw = 0;
        for (int i = 0; i < 3 * N * B; i++) cyc('1, "R9 saturated");
        chk(maxw < BOUND, "R9 wait bound", N'(maxw), N'(BOUND));
        chk(maxw == (N - 1) * B, "R9 rotation length", N'(maxw), N'((N - 1) * B));

        // random toggling of request lines, checked every cycle
        do_reset();
        maxw = 0;
        r = '0;
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < N; b++)
                if (($urandom % 8) == 0) r[b] = ~r[b];
            if (($urandom % 64) == 0) r = '0;
            cyc(r, "R5 random");
        end
        chk(maxw < BOUND, "R9 random wait bound", N'(maxw), N'(BOUND));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule